// File: doc/BRIEF.md
# Per-Stream Continuity Counter Stamper

This block sits on the byte stream between a transport packet scheduler and a network framer. The scheduler sends 188-byte transport packets one byte per valid cycle. With the first byte of each packet it gives a hint: the 13-bit packet identifier, and the number of the counter slot that the identifier uses. The stamper keeps a 4-bit continuity count for each slot. It writes that count into the low nibble of the fourth header byte (byte index 3) and then advances the count. Every other bit of the packet passes through unchanged. The output lags the input by one clock.

The hint is captured only with the start-of-packet byte. The block counts accepted bytes to find the count position and does the update once per packet. Back-to-back packets on the same slot therefore carry consecutive values. Packets with the null identifier 0x1FFF are never counted.

The byte-position machine has four states:
- `ST_IDLE`: waiting for a start byte.
- `ST_LEAD`: bytes 1 to 2.
- `ST_CC`: byte 3 is expected.
- `ST_BODY`: bytes 4 to 187.

Its transitions are:
- Any state to `ST_LEAD` on a valid start byte.
- `ST_LEAD` to `ST_CC` after byte 2.
- `ST_CC` to `ST_BODY` on the stamped byte.
- `ST_BODY` to `ST_IDLE` after byte 187.
- Otherwise the machine stays in its state.

Top module: `cc_stamper`

## Requirements
- R1: After reset the outputs are low and every slot's count is 0, so the first counted packet on any slot carries count 0.
- R2: Every accepted byte that is not a stamped byte appears on `out_data` one clock later, unchanged. `out_valid` and `out_sop` follow `in_valid` and `in_sop` with the same one-clock delay.
- R3: In a counted packet, byte index 3 (the fourth byte, counting the start byte as index 0) leaves with bits 3:0 replaced by the slot's current count. Bits 7:4 are kept.
- R4: For a packet whose hint identifier is 0x1FFF, byte 3 passes unchanged and the slot's count is not advanced.
- R5: Each counted packet advances only its own slot's count, by one. Back-to-back packets on one slot get consecutive values, and other slots keep their counts.
- R6: A count of 15 advances to 0.
- R7: A valid start byte restarts byte counting at index 0 in any state. A packet cut short before its byte 3 does not advance any count.
- R8: Cycles with `in_valid` low do not advance the byte position and produce no output byte.
- R9: The slot and identifier hint is sampled only on the start byte. Changes on `in_slot` or `in_pid` during the rest of the packet have no effect.
- R10: After byte 187, further bytes without a start marker pass unchanged and stamp nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present |
| in_sop | input | 1 | Input byte is the first byte of a packet |
| in_data | input | 8 | Input packet byte |
| in_pid | input | 13 | Packet identifier hint, sampled on the start byte |
| in_slot | input | SLOT_W (3) | Counter slot hint, sampled on the start byte |
| out_valid | output | 1 | Output byte is present |
| out_sop | output | 1 | Output byte is the first byte of a packet |
| out_data | output | 8 | Output byte, stamped at index 3 |

## Verification
On every cycle the assertions check four things:
- A counted stamp moves its slot's count up by exactly one, and 15 wraps to 0.
- A null stamp leaves the count still.
- Unstamped bytes come out unchanged one cycle later.
- The byte position stays in range, and a start byte always restarts it.

Only the bench scenarios can show the following:
- That the count appears at the correct byte and nibble.
- That interleaved slots stay independent.
- That gaps, truncated packets, a hint changing mid-packet and stray bytes after a packet are handled as required.

The bench checks these by comparing every output byte with a per-slot model.

// File: rtl/cc_stamp_pkg.sv
package cc_stamp_pkg;
    localparam int            BYTE_W      = 8;
    localparam int            PID_W       = 13;
    localparam int            CC_W        = 4;
    localparam logic [12:0]   NULL_PID    = 13'h1FFF;
    localparam int            CC_BYTE_IDX = 3;
    localparam int            PKT_BYTES   = 188;

    typedef logic [CC_W-1:0]   cc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_CC   = 2'd2,
        ST_BODY = 2'd3
    } pos_state_t;
endpackage

// File: rtl/cc_pos_tracker.sv
module cc_pos_tracker
    import cc_stamp_pkg::*;
#(
    parameter int PKT_LEN = PKT_BYTES,
    localparam int IDX_W  = $clog2(PKT_LEN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sop,
    output logic       stamp_now,
    output pos_state_t state_o
);
    pos_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (in_valid && in_sop) begin
            state_d = ST_LEAD;
            idx_d   = IDX_W'(1);
        end else if (in_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end
                ST_LEAD: begin
                    idx_d = idx_q + IDX_W'(1);
                    if (idx_q == IDX_W'(CC_BYTE_IDX - 1))
                        state_d = ST_CC;
                end
                ST_CC: begin
                    idx_d   = idx_q + IDX_W'(1);
                    state_d = ST_BODY;
                end
                ST_BODY: begin
                    if (idx_q == IDX_W'(PKT_LEN - 1)) begin
                        idx_d   = '0;
                        state_d = ST_IDLE;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        stamp_now = 1'b0;
        unique case (state_q)
            ST_CC:   stamp_now = in_valid && !in_sop;
            default: stamp_now = 1'b0;
        endcase
        state_o = state_q;
    end

    assert_idx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < IDX_W'(PKT_LEN));

    assert_sop_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |=> (state_q == ST_LEAD));

    assert_single_stamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_now |=> !stamp_now);
endmodule

// File: rtl/cc_slot_table.sv
module cc_slot_table
    import cc_stamp_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] rd_slot,
    output cc_t               rd_val,
    input  logic              bump
);
    cc_t cnt_q [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[s] <= '0;
            else if (bump && (rd_slot == SLOT_W'(s)))
                cnt_q[s] <= cnt_q[s] + cc_t'(1);
        end
    end

    always_comb begin
        rd_val = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            if (rd_slot == SLOT_W'(s))
                rd_val = cnt_q[s];
    end
endmodule

// File: rtl/cc_byte_editor.sv
module cc_byte_editor
    import cc_stamp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  in_sop,
    input  byte_t in_data,
    input  logic  stamp_now,
    input  logic  null_pkt,
    input  cc_t   cc_val,
    output logic  out_valid,
    output logic  out_sop,
    output byte_t out_data
);
    byte_t edit_d;

    always_comb begin
        edit_d = in_data;
        if (stamp_now && !null_pkt)
            edit_d = {in_data[BYTE_W-1:CC_W], cc_val};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_sop   <= in_valid && in_sop;
            if (in_valid)
                out_data <= edit_d;
        end
    end

    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stamp_now) |=> (out_valid && out_data == $past(in_data)));

    assert_upper_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_now |=> (out_data[7:4] == $past(in_data[7:4])));
endmodule

// File: rtl/cc_stamper.sv
module cc_stamper
    import cc_stamp_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int PKT_LEN   = PKT_BYTES,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_data,
    input  logic [12:0]       in_pid,
    input  logic [SLOT_W-1:0] in_slot,
    output logic              out_valid,
    output logic              out_sop,
    output logic [7:0]        out_data
);
    logic [SLOT_W-1:0] hold_slot;
    logic              hold_null;
    logic              stamp_now;
    logic              bump;
    pos_state_t        pos_state;
    cc_t               cc_rd;

    // hint capture on the start byte only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_slot <= '0;
            hold_null <= 1'b0;
        end else if (in_valid && in_sop) begin
            hold_slot <= in_slot;
            hold_null <= (in_pid == NULL_PID);
        end
    end

    cc_pos_tracker #(.PKT_LEN(PKT_LEN)) pos_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .stamp_now(stamp_now),
        .state_o  (pos_state)
    );

    assign bump = stamp_now && !hold_null;

    cc_slot_table #(.NUM_SLOTS(NUM_SLOTS)) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_slot(hold_slot),
        .rd_val (cc_rd),
        .bump   (bump)
    );

    cc_byte_editor edit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_data  (in_data),
        .stamp_now(stamp_now),
        .null_pkt (hold_null),
        .cc_val   (cc_rd),
        .out_valid(out_valid),
        .out_sop  (out_sop),
        .out_data (out_data)
    );

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> (cc_rd == cc_t'($past(cc_rd) + 4'd1)));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && cc_rd == 4'hF) |=> (cc_rd == 4'h0));

    assert_null_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_now && hold_null) |=> $stable(cc_rd));

    assert_stamp_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_now |-> (pos_state == ST_CC));
endmodule

// File: tb/cc_stamper_tb_top.sv
module cc_stamper_tb_top;
    localparam int NSLOT = 8;
    localparam int SW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0]    in_data = '0;
    logic [12:0]   in_pid = '0;
    logic [SW-1:0] in_slot = '0;
    logic          out_valid, out_sop;
    logic [7:0]    out_data;

    int checks = 0, errors = 0, pkt_no = 0;
    bit done = 0;
    logic [3:0] model [NSLOT];
    logic [8:0] q_exp [$];
    string      q_tag [$];

    always #10 clk = ~clk;

    cc_stamper #(.NUM_SLOTS(NSLOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .in_pid(in_pid), .in_slot(in_slot),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: pushes expected bytes into the scoreboard
    task automatic send_pkt(input int slot, input logic [12:0] pid, input int len,
                            input bit gaps, input bit wiggle, input string tag);
        pkt_no++;
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            logic [7:0] e;
            if (gaps) begin
                in_valid = 1'b0; in_sop = 1'b0;
                @(negedge clk);
            end
            d = (i == 0) ? 8'h47 : 8'(i * 7 + slot * 31 + pkt_no * 13);
            e = d;
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_data  = d;
            in_slot  = (wiggle && i > 0) ? SW'(slot + 1) : SW'(slot);
            in_pid   = (wiggle && i > 0) ? 13'h1FFF : pid;
            if (i == 3 && pid != 13'h1FFF) begin
                e = {d[7:4], model[slot]};
                model[slot] = model[slot] + 4'd1;
                q_tag.push_back(tag);
            end else if (i == 3) begin
                q_tag.push_back("R4");
            end else begin
                q_tag.push_back("R2");
            end
            q_exp.push_back({(i == 0), e});
            @(negedge clk);
        end
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic send_stray(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_sop = 1'b0;
            in_data  = 8'(8'h5A + i); in_slot = '0; in_pid = 13'h10;
            q_exp.push_back({1'b0, 8'(8'h5A + i)});
            q_tag.push_back("R10");
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // monitor: pops and compares
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R2 unexpected byte", int'(out_data), 0);
            end else begin
                logic [8:0] x;
                string t;
                x = q_exp.pop_front();
                t = q_tag.pop_front();
                check(out_data == x[7:0], t, int'(out_data), int'(x[7:0]));
                check(out_sop == x[8], "R2 sop", int'(out_sop), int'(x[8]));
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NSLOT; s++) model[s] = 4'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(out_sop == 1'b0,   "R1 out_sop",   int'(out_sop), 0);
        check(out_data == 8'h0,  "R1 out_data",  int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R5 back-to-back on slot 0, first value 0 (R1)
        send_pkt(0, 13'h100, 188, 0, 0, "R3");
        send_pkt(0, 13'h100, 188, 0, 0, "R5");
        send_pkt(0, 13'h100, 188, 0, 0, "R5");
        // R5 interleaved slots
        send_pkt(2, 13'h200, 188, 0, 0, "R5");
        send_pkt(0, 13'h100, 188, 0, 0, "R5");
        send_pkt(2, 13'h200, 188, 0, 0, "R5");
        // R4 null packets on slot 1, then a counted one expects 0
        send_pkt(1, 13'h1FFF, 188, 0, 0, "R4");
        send_pkt(1, 13'h1FFF, 188, 0, 0, "R4");
        send_pkt(1, 13'h101, 188, 0, 0, "R4");
        // R6 wrap on slot 3
        for (int k = 0; k < 17; k++) send_pkt(3, 13'h300, 188, 0, 0, "R6");
        // R8 gaps
        send_pkt(4, 13'h400, 188, 1, 0, "R8");
        send_pkt(4, 13'h400, 188, 0, 0, "R8");
        // R9 hint wiggling after the start byte
        send_pkt(5, 13'h500, 188, 0, 1, "R9");
        send_pkt(6, 13'h600, 188, 0, 0, "R9");
        send_pkt(5, 13'h500, 188, 0, 0, "R9");
        // R7 truncated packets
        send_pkt(7, 13'h700, 2, 0, 0, "R7");
        send_pkt(7, 13'h700, 188, 0, 0, "R7");
        send_pkt(7, 13'h700, 10, 0, 0, "R7");
        send_pkt(7, 13'h700, 188, 0, 0, "R7");
        // R10 stray bytes after a full packet
        send_stray(6);
        send_pkt(7, 13'h700, 188, 0, 0, "R10");
        repeat (5) @(negedge clk);
        check(q_exp.size() == 0, "R2 drained", q_exp.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule